// File: doc/BRIEF.md
# Vector length configuration unit

This unit keeps the vector length state for a vector-capable core. Software configures how many integer and floating-point registers each vector element uses and which of eight register banks are switched on. From these the unit derives the largest vector length the hardware can hold. It then clamps every application length request against that limit.

A configure command or a bank-mask write starts a short serial divider. The divider splits the registers of one bank among the registers in use. The quotient is scaled by the number of enabled banks and capped at the thread limit. While the divider runs, `busy` is high. A length request that arrives during that time is held and applied against the new limit. Further configure or bank commands are dropped until `busy` falls. A packed readback word shows the register-use counts together with the current length.

Top module: `vlen_cfg_unit`

## Requirements
- R1: Out of reset the bank mask is 0xFF, the bank count is 8, integer use and FP use are both 32, the maximum length is 32, the current length is 0 and `busy` is low.
- R2: When integer use plus FP use is 0 or 1, the new maximum is BANK_REGS times the enabled bank count, subject to R4.
- R3: Otherwise the new maximum is floor(BANK_REGS / (integer use + FP use - 1)) times the enabled bank count, subject to R4.
- R4: The maximum length never exceeds MAX_THREADS, and any larger product is replaced by MAX_THREADS.
- R5: A length request accepted while idle sets the current length to the smaller of the request and the maximum on the next clock edge.
- R6: A bank write keeps only bits [7:0] of the written data as the mask. The bank count becomes the number of set bits. The maximum is recomputed using the register-use values that are current at that time. When a configure command arrives in the same cycle, both are taken and they share one computation.
- R7: `cfg_rdata` carries FP use in bits [23:18], integer use in bits [17:12] and the current length zero-extended in bits [11:0], with zeros above.
- R8: A length request made while `busy` is high, or in the same cycle as an accepted configure or bank write, is held. It is applied against the new maximum in the cycle the maximum updates. When several requests are held, the latest one wins.
- R9: A configure command or bank write presented while `busy` is high has no effect.
- R10: After an accepted configure or bank write, `busy` stays high for exactly $clog2(BANK_REGS+1)+1 cycles, which is 10 with the defaults. The new maximum becomes visible as `busy` falls.
- R11: The current length changes only through a length request. A configure command or a bank write leaves it unchanged, even when it then exceeds the new maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Configure command strobe |
| cfg_xuse | input | USE_W | Integer registers used per element |
| cfg_fuse | input | USE_W | FP registers used per element |
| setvl_valid | input | 1 | Length request strobe |
| setvl_len | input | REQ_W | Requested application length |
| bank_wr | input | 1 | Bank-mask write strobe |
| bank_wdata | input | WR_W | Bank-mask write data (low NBANK bits kept) |
| busy | output | 1 | Maximum length being recomputed |
| vl | output | LEN_W | Current vector length |
| vlmax | output | LEN_W | Maximum vector length |
| bank_mask | output | NBANK | Enabled-bank mask |
| cfg_rdata | output | 32 | Packed configuration readback |

## Verification
The assertions check the following on every cycle:
- the maximum stays under the thread cap;
- the bank count matches the popcount of the stored mask;
- a length applied while idle or at the end of a computation never exceeds the maximum;
- the length is never touched without a request;
- commands that arrive while busy leave the stored configuration alone;
- the divider is never started twice or with a zero divisor.

Only the bench scenarios can show the arithmetic itself. That covers the exact quotients for the sum-below-two case and the general case, the cap, the readback packing, the exact busy length, and which of several held requests is finally applied.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
  localparam int RD_LEN_FIELD_W = 12;
  localparam int RD_XUSE_LSB    = 12;
  localparam int RD_FUSE_LSB    = 18;
  localparam int RESET_USE      = 32;
  localparam int RESET_MAXLEN   = 32;
endpackage

// File: rtl/vlc_popcount.sv
module vlc_popcount #(
  parameter int W = 8,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits_in,
  output logic [CW-1:0] ones
);
  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++)
      ones = ones + CW'(bits_in[i]);
  end
endmodule

// File: rtl/vlc_serial_div.sv
module vlc_serial_div #(
  parameter int DIVIDEND = 256,
  parameter int DVS_W    = 7,
  parameter int Q_W      = 9,
  localparam int C_W     = $clog2(Q_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DVS_W-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [Q_W-1:0]   quotient
);
  logic [C_W-1:0]   cnt_q;
  logic [DVS_W-1:0] rem_q, dvs_q;
  logic [Q_W-1:0]   quo_q;
  logic [DVS_W:0]   trial, diff;
  logic             fits;

  assign trial = {rem_q, quo_q[Q_W-1]};
  assign diff  = trial - {1'b0, dvs_q};
  assign fits  = trial >= {1'b0, dvs_q};
  assign busy  = (cnt_q != '0);
  assign quotient = quo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
      quo_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && cnt_q == '0) begin
        cnt_q <= C_W'(Q_W);
        rem_q <= '0;
        dvs_q <= divisor;
        quo_q <= Q_W'(DIVIDEND);
      end else if (cnt_q != '0) begin
        rem_q <= fits ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
        quo_q <= {quo_q[Q_W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == C_W'(1)) done <= 1'b1;
      end
    end
  end

  assert_divisor_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    start |-> (divisor != '0));
  assert_start_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
    start |-> (!busy && !done));
  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/vlc_len_limit.sv
module vlc_len_limit #(
  parameter int Q_W         = 9,
  parameter int CNT_W       = 4,
  parameter int MAX_THREADS = 2048,
  parameter int LEN_W       = 12,
  localparam int PROD_W     = Q_W + CNT_W
) (
  input  logic [Q_W-1:0]   quo,
  input  logic [CNT_W-1:0] banks,
  output logic [LEN_W-1:0] max_len
);
  logic [PROD_W-1:0] prod;
  assign prod = PROD_W'(quo) * PROD_W'(banks);
  always_comb begin
    if (32'(prod) > 32'(MAX_THREADS)) max_len = LEN_W'(MAX_THREADS);
    else                              max_len = LEN_W'(prod);
  end
endmodule

// File: rtl/vlen_cfg_unit.sv
module vlen_cfg_unit
  import vlc_pkg::*;
#(
  parameter int BANK_REGS   = 256,
  parameter int MAX_THREADS = 2048,
  parameter int USE_W       = 6,
  parameter int REQ_W       = 16,
  parameter int NBANK       = 8,
  parameter int WR_W        = 16,
  localparam int LEN_W      = $clog2(MAX_THREADS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_valid,
  input  logic [USE_W-1:0] cfg_xuse,
  input  logic [USE_W-1:0] cfg_fuse,
  input  logic             setvl_valid,
  input  logic [REQ_W-1:0] setvl_len,
  input  logic             bank_wr,
  input  logic [WR_W-1:0]  bank_wdata,
  output logic             busy,
  output logic [LEN_W-1:0] vl,
  output logic [LEN_W-1:0] vlmax,
  output logic [NBANK-1:0] bank_mask,
  output logic [31:0]      cfg_rdata
);
  localparam int Q_W   = $clog2(BANK_REGS + 1);
  localparam int SUM_W = USE_W + 1;
  localparam int CNT_W = $clog2(NBANK + 1);
  localparam logic [LEN_W-1:0] RST_MAX =
    LEN_W'((RESET_MAXLEN < MAX_THREADS) ? RESET_MAXLEN : MAX_THREADS);

  logic [USE_W-1:0] xuse_q, fuse_q, xuse_n, fuse_n;
  logic [NBANK-1:0] mask_q, mask_n;
  logic [CNT_W-1:0] bcnt_q, bcnt_n;
  logic [LEN_W-1:0] vl_q, vlmax_q, max_new;
  logic             pend_v;
  logic [REQ_W-1:0] pend_len, req_sel;
  logic [SUM_W-1:0] use_sum, divisor;
  logic [Q_W-1:0]   quo;
  logic             div_busy, div_done, busy_q, start;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [REQ_W-1:0] req,
                                                 input logic [LEN_W-1:0] lim);
    if (REQ_W'(lim) < req) return lim;
    return LEN_W'(req);
  endfunction

  assign busy_q  = div_busy | div_done;
  assign start   = !busy_q && (cfg_valid || bank_wr);
  assign xuse_n  = cfg_valid ? cfg_xuse : xuse_q;
  assign fuse_n  = cfg_valid ? cfg_fuse : fuse_q;
  assign mask_n  = bank_wdata[NBANK-1:0];
  assign use_sum = SUM_W'(xuse_n) + SUM_W'(fuse_n);
  assign divisor = (use_sum < SUM_W'(2)) ? SUM_W'(1) : use_sum - SUM_W'(1);
  assign req_sel = setvl_valid ? setvl_len : pend_len;

  vlc_popcount #(.W(NBANK)) u_pop (.bits_in(mask_n), .ones(bcnt_n));

  vlc_serial_div #(.DIVIDEND(BANK_REGS), .DVS_W(SUM_W), .Q_W(Q_W)) u_div (
    .clk(clk), .rst(rst), .start(start), .divisor(divisor),
    .busy(div_busy), .done(div_done), .quotient(quo));

  vlc_len_limit #(.Q_W(Q_W), .CNT_W(CNT_W), .MAX_THREADS(MAX_THREADS),
                  .LEN_W(LEN_W)) u_lim (.quo(quo), .banks(bcnt_q), .max_len(max_new));

  always_ff @(posedge clk) begin
    if (rst) begin
      xuse_q   <= USE_W'(RESET_USE);
      fuse_q   <= USE_W'(RESET_USE);
      mask_q   <= '1;
      bcnt_q   <= CNT_W'(NBANK);
      vl_q     <= '0;
      vlmax_q  <= RST_MAX;
      pend_v   <= 1'b0;
      pend_len <= '0;
    end else begin
      if (start) begin
        if (cfg_valid) begin
          xuse_q <= cfg_xuse;
          fuse_q <= cfg_fuse;
        end
        if (bank_wr) begin
          mask_q <= mask_n;
          bcnt_q <= bcnt_n;
        end
      end
      if (div_done) begin
        vlmax_q <= max_new;
        if (setvl_valid || pend_v) vl_q <= clamp_len(req_sel, max_new);
        pend_v <= 1'b0;
      end else if (setvl_valid) begin
        if (busy_q || start) begin
          pend_v   <= 1'b1;
          pend_len <= setvl_len;
        end else begin
          vl_q <= clamp_len(setvl_len, vlmax_q);
        end
      end
    end
  end

  assign busy      = busy_q;
  assign vl        = vl_q;
  assign vlmax     = vlmax_q;
  assign bank_mask = mask_q;
  assign cfg_rdata = (32'(fuse_q) << RD_FUSE_LSB) | (32'(xuse_q) << RD_XUSE_LSB)
                   | 32'(vl_q);

  assert_vlmax_cap_R4: assert property (@(posedge clk) disable iff (rst)
    32'(vlmax_q) <= 32'(MAX_THREADS));
  assert_bank_count_R6: assert property (@(posedge clk) disable iff (rst)
    $countones(mask_q) == 32'(bcnt_q));
  assert_idle_setvl_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (setvl_valid && !busy_q && !start) |=> (vl_q <= vlmax_q));
  assert_held_setvl_bound_R8: assert property (@(posedge clk) disable iff (rst)
    (div_done && (setvl_valid || pend_v)) |=> (vl_q <= vlmax_q));
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (rst)
    (busy_q && (cfg_valid || bank_wr)) |=>
      (xuse_q == $past(xuse_q) && fuse_q == $past(fuse_q) && mask_q == $past(mask_q)));
  assert_vl_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!setvl_valid && !div_done) |=> $stable(vl_q));
endmodule

// File: tb/vlen_cfg_unit_tb_top.sv
module vlen_cfg_unit_tb_top;
  localparam int MAXT = 1000;
  localparam int BR   = 256;
  localparam int LW   = $clog2(MAXT + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_valid = 0, setvl_valid = 0, bank_wr = 0;
  logic [5:0] cfg_xuse = 0, cfg_fuse = 0;
  logic [15:0] setvl_len = 0, bank_wdata = 0;
  logic busy;
  logic [LW-1:0] vl, vlmax;
  logic [7:0] bank_mask;
  logic [31:0] cfg_rdata;

  always #2 clk = ~clk;

  vlen_cfg_unit #(.BANK_REGS(BR), .MAX_THREADS(MAXT)) dut_i (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_xuse(cfg_xuse),
    .cfg_fuse(cfg_fuse), .setvl_valid(setvl_valid), .setvl_len(setvl_len),
    .bank_wr(bank_wr), .bank_wdata(bank_wdata), .busy(busy), .vl(vl),
    .vlmax(vlmax), .bank_mask(bank_mask), .cfg_rdata(cfg_rdata));

  typedef struct { string tag; int vl; int vlmax; int rdata; int mask; } exp_t;
  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  int m_int, m_fp, m_mask, m_vl, m_max;

  function automatic int calc_max(int xi, int fi, int mk);
    int cnt = 0, s = xi + fi, r;
    for (int i = 0; i < 8; i++) cnt += (mk >> i) & 1;
    r = (s < 2) ? BR * cnt : (BR / (s - 1)) * cnt;
    return (r > MAXT) ? MAXT : r;
  endfunction

  function automatic int min2(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic check(string tag, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // driver side: push the model state, monitor compares at the next negedge
  task automatic expect_now(string tag);
    exp_t e;
    e.tag = tag; e.vl = m_vl; e.vlmax = m_max; e.mask = m_mask;
    e.rdata = (m_fp << 18) | (m_int << 12) | m_vl;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if (int'(vl) != e.vl || int'(vlmax) != e.vlmax || int'(cfg_rdata) != e.rdata
          || int'(bank_mask) != e.mask || busy) begin
        n_fail++;
        $display("FAIL %s actual vl=%0d max=%0d rd=%h mask=%h busy=%0d expected vl=%0d max=%0d rd=%h mask=%h busy=0",
                 e.tag, vl, vlmax, cfg_rdata, bank_mask, busy, e.vl, e.vlmax, e.rdata, e.mask);
      end
    end
  end

  task automatic issue(bit c, int xi, int fi, bit s, int len, bit b, int bw);
    cfg_valid = c; cfg_xuse = 6'(xi); cfg_fuse = 6'(fi);
    setvl_valid = s; setvl_len = 16'(len);
    bank_wr = b; bank_wdata = 16'(bw);
    @(negedge clk);
    cfg_valid = 0; setvl_valid = 0; bank_wr = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic do_setvl(int len, string tag);
    issue(0, 0, 0, 1, len, 0, 0);
    m_vl = min2(len, m_max);
    expect_now(tag);
  endtask

  task automatic do_cfg(int xi, int fi, string tag);
    issue(1, xi, fi, 0, 0, 0, 0);
    wait_idle();
    m_int = xi; m_fp = fi; m_max = calc_max(m_int, m_fp, m_mask);
    expect_now(tag);
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    int blen;
    repeat (4) @(negedge clk);
    rst = 0;
    m_int = 32; m_fp = 32; m_mask = 'hFF; m_vl = 0; m_max = 32;
    expect_now("R1 reset state");

    do_setvl(100, "R5 request above reset max");
    do_setvl(7, "R5 request below max");

    // R10: busy length, R2 with sum one, R4 cap, R11 vl kept
    issue(1, 1, 0, 0, 0, 0, 0);
    blen = 0;
    while (busy) begin blen++; @(negedge clk); end
    check("R10 busy cycles", blen, $clog2(BR + 1) + 1);
    m_int = 1; m_fp = 0; m_max = calc_max(1, 0, m_mask);
    check("R4 cap expected value", m_max, MAXT);
    expect_now("R2 R4 R11 sum one");

    do_cfg(0, 0, "R2 R4 sum zero");
    do_cfg(3, 2, "R3 R7 general quotient");
    do_setvl(600, "R5 clamp to 512");

    // R6 bank write keeps low 8 bits, vl untouched (R11)
    issue(0, 0, 0, 0, 0, 1, 'h1A5);
    wait_idle();
    m_mask = 'hA5; m_max = calc_max(m_int, m_fp, m_mask);
    expect_now("R6 R11 bank write low bits");

    do_cfg(10, 7, "R3 R7 sum seventeen");

    // R8 request together with the start
    issue(1, 20, 20, 1, 50, 0, 0);
    wait_idle();
    m_int = 20; m_fp = 20; m_max = calc_max(20, 20, m_mask); m_vl = min2(50, m_max);
    expect_now("R8 request with start");

    // R8 latest held request wins, R9 commands while busy dropped
    issue(1, 2, 2, 0, 0, 0, 0);
    check("R9 busy after accept", int'(busy), 1);
    issue(0, 0, 0, 1, 5, 0, 0);
    issue(1, 1, 1, 1, 200, 1, 'h0F);
    wait_idle();
    m_int = 2; m_fp = 2; m_max = calc_max(2, 2, m_mask); m_vl = min2(200, m_max);
    expect_now("R8 R9 held request and dropped commands");

    // R6 empty mask, R11 vl above new max
    issue(0, 0, 0, 0, 0, 1, 'h00);
    wait_idle();
    m_mask = 0; m_max = 0;
    expect_now("R6 R11 empty mask");
    do_setvl(9, "R5 clamp to zero max");

    // R6 bank and configure in the same cycle
    issue(1, 63, 63, 0, 0, 1, 'hFF);
    wait_idle();
    m_int = 63; m_fp = 63; m_mask = 'hFF; m_max = calc_max(63, 63, 'hFF);
    expect_now("R6 R3 joint command");
    do_setvl(16, "R5 request equal max");
    do_setvl(17, "R5 request one above max");
    do_setvl(0, "R5 zero request");

    @(negedge clk);
    summary();
    $finish;
  end
endmodule